// File: doc/BRIEF.md
# Multiplexed Dynamic-Width Bus Controller

This block carries out external memory accesses for a processor core. The core issues requests on a simple interface: address, write data, byte or word size, read or write, and an instruction-fetch flag. The block runs them on a 16-bit bus that multiplexes address and data on the same wires. It drives the address strobe, the read strobe, the write strobe or strobes, the high-lane signal and an instruction-fetch marker. It also stretches each cycle with wait states while the memory holds READY low.

The bus width can change from one cycle to the next. With dynamic width enabled, a width pin is sampled after the address phase and selects a 16-bit or an 8-bit transfer. With dynamic width disabled, every transfer is 8 bits wide. A word access that lands on an 8-bit cycle is completed as a second byte cycle at the odd address. The core is acknowledged once, with the word already reassembled. Three configuration inputs select how the address strobe and the write strobes are encoded, and a 2-bit field caps the number of wait states.

Time is counted in controller clocks. One clock stands for one state time of the bus.

Top module: `mbc_bus_ctrl`

## Requirements
- R1: Each bus cycle has a fixed order: an address clock, one gap clock, then `ACT_LEN` (default 3) strobe clocks plus any wait clocks, then an end clock in which `req_ack_o` pulses for one clock. The read or write strobe goes active one clock after the address strobe ends. A request accepted in idle and completed in a single cycle with no waits is acknowledged 6 clocks after it is accepted.
- R2: If `cfg_dyn_width_i` is 1, the level of `buswidth_i` in the gap clock picks the width of the cycle: 1 gives 16 bits and 0 gives 8 bits. Its level in any other clock has no effect. If `cfg_dyn_width_i` is 0, every cycle is 8 bits wide.
- R3: A word request on an 8-bit cycle runs as two cycles back to back. The first goes to the even address. The second goes to that address plus one and carries the high byte. For reads, the byte from the second cycle becomes bits 15:8 of `rsp_rdata_o`.
- R4: In combined-strobe mode (`cfg_split_wr_i`=0), `ad_o[0]` in the address clock is the lane-0 select. `bhe_n_o` is a level that is low from the address clock to the end clock when the upper lane is used (a word, or an odd address) and high otherwise. A word request is always issued at the even address.
- R5: In split-strobe mode (`cfg_split_wr_i`=1), `wr_n_o` is the low-lane write strobe and `bhe_n_o` is the high-lane write strobe. On a 16-bit cycle, the low strobe pulses for even-address writes and the high strobe pulses for word writes or odd-address writes. On an 8-bit cycle, only the low strobe pulses. With combined strobes, `wr_n_o` pulses on every write cycle.
- R6: With `cfg_adv_strobe_i`=0, `as_o` is a high pulse during the address clock and is low otherwise. With `cfg_adv_strobe_i`=1, `as_o` is low from the address clock until the last strobe clock, goes high in the end clock, and is high while idle.
- R7: If READY is low in the last strobe clock or in a wait clock, the strobe is extended by one clock. READY has no effect while no cycle is in progress.
- R8: `cfg_wait_lim_i` caps the number of wait clocks per bus cycle at 0, 1 or 2. The value 3 means waiting on READY with no limit. When the cap is reached, the cycle ends as though READY were high.
- R9: `inst_o` is high from the address clock to the end clock of every read cycle that belongs to an instruction-fetch request. It is low for writes and while idle.
- R10: A byte read returns zero in bits 15:8. On a 16-bit cycle the byte comes from the upper lane when the address is odd and from the lower lane when it is even. On an 8-bit cycle it comes from the lower lane. During a byte write, the data byte from `req_wdata_i[7:0]` is driven on both lanes. The second cycle of a split word write drives the high byte on both lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one bus state time |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Core request pending; held until acknowledged |
| req_addr_i | input | 16 | Request byte address |
| req_wdata_i | input | 16 | Write data; a byte write uses bits 7:0 |
| req_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| req_ack_o | output | 1 | One-clock completion pulse |
| rsp_rdata_o | output | 16 | Read data, valid with the acknowledge |
| cfg_dyn_width_i | input | 1 | Enables per-cycle width selection from the pin |
| cfg_adv_strobe_i | input | 1 | Address strobe held as a cycle-long active-low select |
| cfg_split_wr_i | input | 1 | Selects separate low and high write strobes |
| cfg_wait_lim_i | input | 2 | Wait-state cap; 3 = no limit |
| buswidth_i | input | 1 | Width pin, sampled in the gap clock |
| ready_i | input | 1 | Memory ready; low inserts wait clocks |
| ad_i | input | 16 | Bus read value |
| ad_o | output | 16 | Bus drive value: address, then write data |
| ad_oe_o | output | 1 | Bus output enable |
| as_o | output | 1 | Address strobe (pulse or select, per mode) |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe or low-lane write strobe, active low |
| bhe_n_o | output | 1 | High-lane enable or high-lane write strobe, active low |
| inst_o | output | 1 | Instruction-fetch marker |

## Verification
Two events can fall in the same cycle: wait-state stretching and the narrowing of a word access into two byte cycles. When both happen, every half of the split word must take its own waits and must restart its own wait count. The bench provokes this by holding READY low with dynamic width disabled and a cap of one. It then checks the total latency of 14 clocks, the 8 read-strobe clocks, the two address strobes and the reassembled word. A second pairing changes the width pin between the address clock and the gap clock, in both directions. Only the gap-clock level may decide whether the word splits.

// File: rtl/mbc_pkg.sv
`timescale 1ns/1ps
package mbc_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = BUS_W / 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GAP,
        ST_ACT,
        ST_END
    } bus_st_e;

    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] wdata;
        logic             word;
        logic             write;
        logic             fetch;
    } bus_req_t;

    // Data placed on the bus during the data phase of a write.
    function automatic logic [BUS_W-1:0] lane_place(input bus_req_t r, input logic second);
        if (second)
            return {2{r.wdata[BUS_W-1:BYTE_W]}};
        else if (r.word)
            return r.wdata;
        else
            return {2{r.wdata[BYTE_W-1:0]}};
    endfunction

endpackage

// File: rtl/mbc_seq.sv
`timescale 1ns/1ps
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int ACT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_word,
    input  logic       dyn_width,
    input  logic [1:0] wait_lim,
    input  logic       buswidth,
    input  logic       ready,
    output bus_st_e    state_o,
    output logic       ph2_o,
    output logic       w16_o,
    output logic       cap_o,
    output logic       ack_o
);
    localparam int CNT_W = $clog2(ACT_LEN + 1);

    bus_st_e          state;
    logic [CNT_W-1:0] act_cnt;
    logic [1:0]       wait_cnt;
    logic             ph2, w16;
    logic             base_done, hold, split_more;

    assign base_done  = (state == ST_ACT) && (act_cnt == CNT_W'(ACT_LEN - 1));
    assign hold       = base_done && !ready && ((wait_lim == 2'd3) || (wait_cnt < wait_lim));
    assign split_more = (state == ST_END) && req_word && !w16 && !ph2;

    assign cap_o   = base_done && !hold;
    assign ack_o   = (state == ST_END) && !split_more;
    assign state_o = state;
    assign ph2_o   = ph2;
    assign w16_o   = w16;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            act_cnt  <= '0;
            wait_cnt <= '0;
            ph2      <= 1'b0;
            w16      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state <= ST_ADDR;
                    ph2   <= 1'b0;
                end
                ST_ADDR: state <= ST_GAP;
                ST_GAP: begin
                    w16      <= dyn_width & buswidth;
                    act_cnt  <= '0;
                    wait_cnt <= '0;
                    state    <= ST_ACT;
                end
                ST_ACT: begin
                    if (!base_done)
                        act_cnt <= act_cnt + CNT_W'(1);
                    else if (hold) begin
                        if (wait_cnt != 2'd3)
                            wait_cnt <= wait_cnt + 2'd1;
                    end else
                        state <= ST_END;
                end
                ST_END: begin
                    if (split_more) begin
                        state <= ST_ADDR;
                        ph2   <= 1'b1;
                    end else
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: a capped cycle never counts past its cap
    p_wait_cap_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACT && wait_lim != 2'd3) |-> (wait_cnt <= wait_lim));

    // R1: the gap clock always leads into a fresh strobe phase
    p_gap_to_act_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |=> (state == ST_ACT && act_cnt == '0 && wait_cnt == '0));

    // R7: with no request the controller stays idle whatever READY does
    p_idle_stay_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !req_valid) |=> (state == ST_IDLE));

    // R3: a second byte cycle only follows the end of the first
    p_second_follows_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && ph2) |-> ($past(state) == ST_END));

endmodule

// File: rtl/mbc_pins.sv
`timescale 1ns/1ps
module mbc_pins
    import mbc_pkg::*;
(
    input  bus_st_e          state,
    input  logic             ph2,
    input  logic             w16,
    input  logic             adv_mode,
    input  logic             split_wr,
    input  bus_req_t         req,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe_o,
    output logic             as_o,
    output logic             rd_n_o,
    output logic             wr_n_o,
    output logic             bhe_n_o,
    output logic             inst_o
);
    logic in_cyc, strobe, a0, hi_used, lo_wr, hi_wr;

    assign in_cyc  = state inside {ST_ADDR, ST_GAP, ST_ACT, ST_END};
    assign strobe  = (state == ST_ACT);
    assign a0      = req.addr[0] | ph2;
    assign hi_used = (req.word && !ph2) || a0;
    assign lo_wr   = !w16 || !a0;
    assign hi_wr   = w16 && hi_used;

    assign as_o    = adv_mode ? !(state inside {ST_ADDR, ST_GAP, ST_ACT})
                              : (state == ST_ADDR);
    assign rd_n_o  = !(strobe && !req.write);
    assign wr_n_o  = split_wr ? !(strobe && req.write && lo_wr)
                              : !(strobe && req.write);
    assign bhe_n_o = split_wr ? !(strobe && req.write && hi_wr)
                              : !(in_cyc && hi_used);
    assign inst_o  = in_cyc && req.fetch && !req.write;
    assign ad_oe_o = (state == ST_ADDR) ||
                     (req.write && (state inside {ST_GAP, ST_ACT, ST_END}));
    assign ad_o    = (state == ST_ADDR) ? {req.addr[BUS_W-1:1], a0}
                                        : lane_place(req, ph2);

endmodule

// File: rtl/mbc_rdasm.sv
`timescale 1ns/1ps
module mbc_rdasm
    import mbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             ph2,
    input  logic             w16,
    input  logic             word,
    input  logic             a0,
    input  logic [BUS_W-1:0] ad_i,
    output logic [BUS_W-1:0] rdata_o
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata_o <= '0;
        else if (cap) begin
            if (ph2)
                rdata_o[BUS_W-1:BYTE_W] <= ad_i[BYTE_W-1:0];
            else if (word)
                rdata_o <= w16 ? ad_i : {{BYTE_W{1'b0}}, ad_i[BYTE_W-1:0]};
            else
                rdata_o <= {{BYTE_W{1'b0}},
                            (w16 && a0) ? ad_i[BUS_W-1:BYTE_W] : ad_i[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/mbc_bus_ctrl.sv
`timescale 1ns/1ps
module mbc_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int ACT_LEN = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid_i,
    input  logic [15:0] req_addr_i,
    input  logic [15:0] req_wdata_i,
    input  logic        req_word_i,
    input  logic        req_write_i,
    input  logic        req_fetch_i,
    output logic        req_ack_o,
    output logic [15:0] rsp_rdata_o,
    input  logic        cfg_dyn_width_i,
    input  logic        cfg_adv_strobe_i,
    input  logic        cfg_split_wr_i,
    input  logic [1:0]  cfg_wait_lim_i,
    input  logic        buswidth_i,
    input  logic        ready_i,
    input  logic [15:0] ad_i,
    output logic [15:0] ad_o,
    output logic        ad_oe_o,
    output logic        as_o,
    output logic        rd_n_o,
    output logic        wr_n_o,
    output logic        bhe_n_o,
    output logic        inst_o
);
    bus_req_t q;
    bus_st_e  st;
    logic     ph2, w16, cap;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (st == ST_IDLE && req_valid_i)
            q <= '{addr:  {req_addr_i[BUS_W-1:1], req_addr_i[0] & ~req_word_i},
                   wdata: req_wdata_i,
                   word:  req_word_i,
                   write: req_write_i,
                   fetch: req_fetch_i};
    end

    mbc_seq #(.ACT_LEN(ACT_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid_i),
        .req_word  (q.word),
        .dyn_width (cfg_dyn_width_i),
        .wait_lim  (cfg_wait_lim_i),
        .buswidth  (buswidth_i),
        .ready     (ready_i),
        .state_o   (st),
        .ph2_o     (ph2),
        .w16_o     (w16),
        .cap_o     (cap),
        .ack_o     (req_ack_o)
    );

    mbc_pins u_pins (
        .state    (st),
        .ph2      (ph2),
        .w16      (w16),
        .adv_mode (cfg_adv_strobe_i),
        .split_wr (cfg_split_wr_i),
        .req      (q),
        .ad_o     (ad_o),
        .ad_oe_o  (ad_oe_o),
        .as_o     (as_o),
        .rd_n_o   (rd_n_o),
        .wr_n_o   (wr_n_o),
        .bhe_n_o  (bhe_n_o),
        .inst_o   (inst_o)
    );

    mbc_rdasm u_rdasm (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .ph2     (ph2),
        .w16     (w16),
        .word    (q.word),
        .a0      (q.addr[0]),
        .ad_i    (ad_i),
        .rdata_o (rsp_rdata_o)
    );

    // R1: the acknowledge is a single-clock pulse
    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        req_ack_o |=> !req_ack_o);

    // R1: read strobe opens one clock after the latch pulse ended
    p_gap_before_rd_r1: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_n_o) && !cfg_adv_strobe_i) |-> (!$past(as_o) && $past(as_o, 2)));

    // R6: in select mode the address strobe is active while reading
    p_adv_covers_rd_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_adv_strobe_i && !rd_n_o) |-> !as_o);

    // R9: a fetch read keeps the marker up while the read strobe is low
    p_inst_on_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_o && q.fetch) |-> inst_o);

    // R10: a byte read acknowledges with a zero upper byte
    p_byte_hi_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (req_ack_o && !q.word && !q.write) |-> (rsp_rdata_o[15:8] == 8'h00));

endmodule

// File: tb/mbc_bus_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbc_bus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        req_word = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic        cfg_dyn = 1'b0, cfg_adv = 1'b0, cfg_split = 1'b0;
    logic [1:0]  cfg_lim = 2'd0;
    logic        buswidth = 1'b0, ready = 1'b1;
    logic [15:0] rbus = '0;
    logic        lat_a0 = 1'b0;
    logic [15:0] ad_i;
    logic        req_ack, ad_oe, as_s, rd_n, wr_n, bhe_n, inst;
    logic [15:0] rdata, ad_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    // memory model: an odd latched address returns the upper byte on both lanes
    assign ad_i = lat_a0 ? {rbus[15:8], rbus[15:8]} : rbus;

    mbc_bus_ctrl dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .req_word_i(req_word), .req_write_i(req_write), .req_fetch_i(req_fetch),
        .req_ack_o(req_ack), .rsp_rdata_o(rdata),
        .cfg_dyn_width_i(cfg_dyn), .cfg_adv_strobe_i(cfg_adv),
        .cfg_split_wr_i(cfg_split), .cfg_wait_lim_i(cfg_lim),
        .buswidth_i(buswidth), .ready_i(ready), .ad_i(ad_i),
        .ad_o(ad_o), .ad_oe_o(ad_oe), .as_o(as_s), .rd_n_o(rd_n),
        .wr_n_o(wr_n), .bhe_n_o(bhe_n), .inst_o(inst)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 60000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        dyn, adv, split;
        logic [1:0]  lim;
        logic        bw, rl, word, write, fetch;
        logic [15:0] addr, wdata, rb, exp_rd;
        logic [7:0]  lat;
        logic [1:0]  ncyc, wrl, hfall;
        logic        bhe0, inst0;
        logic [15:0] wd;
        logic [3:0]  rdclk;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,1'b0,1'b1,16'h1234,16'h0000,16'hBEEF,16'hBEEF,8'd6, 2'd1,2'd0,2'd1,1'b0,1'b1,16'h0000,4'd3},
        '{1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,16'h2000,16'h0000,16'hA55A,16'hA55A,8'd12,2'd2,2'd0,2'd1,1'b0,1'b0,16'h0000,4'd6},
        '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,16'h0010,16'h1357,16'h0000,16'h0000,8'd12,2'd2,2'd2,2'd1,1'b0,1'b0,16'h1313,4'd0},
        '{1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,16'h0020,16'hC0DE,16'h0000,16'h0000,8'd6, 2'd1,2'd1,2'd1,1'b1,1'b0,16'hC0DE,4'd0},
        '{1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,16'h0031,16'h0077,16'h0000,16'h0000,8'd6, 2'd1,2'd0,2'd1,1'b1,1'b0,16'h7777,4'd0},
        '{1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,16'h0040,16'h0066,16'h0000,16'h0000,8'd6, 2'd1,2'd1,2'd0,1'b1,1'b0,16'h6666,4'd0},
        '{1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,16'h0041,16'h0055,16'h0000,16'h0000,8'd6, 2'd1,2'd1,2'd0,1'b1,1'b0,16'h5555,4'd0},
        '{1'b1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0051,16'h0000,16'h9A3C,16'h009A,8'd6, 2'd1,2'd0,2'd1,1'b0,1'b0,16'h0000,4'd3},
        '{1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0060,16'h0000,16'h9A3C,16'h003C,8'd6, 2'd1,2'd0,2'd0,1'b1,1'b0,16'h0000,4'd3},
        '{1'b1,1'b0,1'b0,2'd2,1'b1,1'b1,1'b1,1'b0,1'b1,16'h0100,16'h0000,16'h4242,16'h4242,8'd8, 2'd1,2'd0,2'd1,1'b0,1'b1,16'h0000,4'd5},
        '{1'b0,1'b0,1'b0,2'd1,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0200,16'h0000,16'h1E2D,16'h1E2D,8'd14,2'd2,2'd0,2'd1,1'b0,1'b0,16'h0000,4'd8},
        '{1'b1,1'b0,1'b0,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0300,16'h0000,16'h7788,16'h7788,8'd6, 2'd1,2'd0,2'd1,1'b0,1'b0,16'h0000,4'd3},
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b0,1'b1,1'b1,1'b1,16'h0400,16'hABCD,16'h0000,16'h0000,8'd6, 2'd1,2'd1,2'd1,1'b0,1'b0,16'hABCD,4'd0}
    };

    // Drives one request at a falling edge and watches the pins until the acknowledge.
    task automatic run_vec(input vec_t v, input int idx);
        int   n = 0, ncyc = 0, wrl = 0, hfall = 0, rdclk = 0;
        logic got = 1'b0, first = 1'b1, aph;
        logic prev_as, prev_wr = 1'b1, prev_h = 1'b1;
        logic [15:0] addr0 = '0, wd = '0, rd = '0;
        logic bhe0 = 1'b1, inst0 = 1'b0;
        cfg_dyn = v.dyn; cfg_adv = v.adv; cfg_split = v.split; cfg_lim = v.lim;
        buswidth = v.bw; ready = !v.rl; rbus = v.rb; lat_a0 = 1'b0;
        req_addr = v.addr; req_wdata = v.wdata; req_word = v.word;
        req_write = v.write; req_fetch = v.fetch; req_valid = 1'b1;
        prev_as = v.adv;
        while (!got && n < 100) begin
            @(negedge clk);
            n++;
            aph = v.adv ? (!as_s && prev_as) : (as_s && !prev_as);
            if (aph) begin
                ncyc++;
                lat_a0 = ad_o[0];
                if (first) begin
                    addr0 = ad_o; bhe0 = bhe_n; inst0 = inst; first = 1'b0;
                end
            end
            if (!wr_n && prev_wr) wrl++;
            if (!bhe_n && prev_h) hfall++;
            if (!rd_n) rdclk++;
            if (!wr_n || (v.split && !bhe_n)) wd = ad_o;
            if (req_ack) begin
                got = 1'b1; rd = rdata; req_valid = 1'b0;
            end
            prev_as = as_s; prev_wr = wr_n; prev_h = bhe_n;
        end
        ready = 1'b1;
        chk($sformatf("R1 R7 R8 latency v%0d", idx), n, v.lat);
        chk($sformatf("R3 bus cycle count v%0d", idx), ncyc, v.ncyc);
        chk($sformatf("R4 first address v%0d", idx), addr0,
            {v.addr[15:1], v.addr[0] & ~v.word});
        chk($sformatf("R4 R5 high-lane pin at address v%0d", idx), bhe0, v.bhe0);
        chk($sformatf("R9 fetch marker v%0d", idx), inst0, v.inst0);
        chk($sformatf("%s high-lane falls v%0d", v.split ? "R5" : "R4", idx), hfall, v.hfall);
        chk($sformatf("R5 write strobe pulses v%0d", idx), wrl, v.wrl);
        chk($sformatf("R1 R7 read strobe clocks v%0d", idx), rdclk, v.rdclk);
        if (v.write)
            chk($sformatf("R10 write data drive v%0d", idx), wd, v.wd);
        else
            chk($sformatf("R10 R3 read data v%0d", idx), rd, v.exp_rd);
        @(negedge clk);
    endtask

    task automatic issue_read(input logic [15:0] a, input logic word);
        req_addr = a; req_word = word; req_write = 1'b0; req_fetch = 1'b0;
        req_valid = 1'b1;
    endtask

    // R2: width pin changed after the address clock; returns clocks to acknowledge
    task automatic run_bw_flip(input logic bw0, output int n);
        n = 0;
        cfg_dyn = 1'b1; cfg_adv = 1'b0; cfg_split = 1'b0; cfg_lim = 2'd0;
        buswidth = bw0; ready = 1'b1; rbus = 16'h6C5E; lat_a0 = 1'b0;
        issue_read(16'h0500, 1'b1);
        while (n < 100) begin
            @(negedge clk);
            n++;
            if (n == 1) buswidth = !bw0;
            if (req_ack) break;
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int   lat;
        logic [5:0] as_pat, rd_pat;
        logic seen;
        repeat (3) @(negedge clk);
        // reset state, R1 R6
        chk("R1 reset rd_n", rd_n, 1'b1);
        chk("R1 reset wr_n", wr_n, 1'b1);
        chk("R4 reset bhe_n", bhe_n, 1'b1);
        chk("R1 reset bus enable", ad_oe, 1'b0);
        chk("R1 reset ack", req_ack, 1'b0);
        chk("R9 reset inst", inst, 1'b0);
        chk("R6 reset latch strobe", as_s, 1'b0);
        cfg_adv = 1'b1;
        #1 chk("R6 idle select strobe high", as_s, 1'b1);
        cfg_adv = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R7: READY low while idle is ignored
        ready = 1'b0;
        repeat (5) @(negedge clk);
        run_vec(VECS[0], 100);

        // R1 R6: strobe ordering in both address-strobe modes
        for (int m = 0; m < 2; m++) begin
            cfg_adv = m[0]; cfg_dyn = 1'b1; buswidth = 1'b1; cfg_split = 1'b0;
            cfg_lim = 2'd0; ready = 1'b1; lat_a0 = 1'b0;
            issue_read(16'h0600, 1'b1);
            as_pat = '0; rd_pat = '0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                as_pat[k] = as_s; rd_pat[k] = rd_n;
            end
            req_valid = 1'b0;
            chk(m == 0 ? "R1 latch pulse pattern" : "R6 select strobe pattern",
                as_pat, m == 0 ? 6'b000001 : 6'b100000);
            chk("R1 read strobe pattern", rd_pat, 6'b100011);
            @(negedge clk);
        end
        cfg_adv = 1'b0;

        // R8: cap value 3 waits on READY with no limit
        cfg_lim = 2'd3; ready = 1'b0; lat_a0 = 1'b0;
        issue_read(16'h0700, 1'b1);
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (req_ack) seen = 1'b1;
        end
        chk("R8 unlimited wait holds", seen, 1'b0);
        ready = 1'b1;
        @(negedge clk);
        chk("R8 release ends cycle", req_ack, 1'b1);
        req_valid = 1'b0;
        @(negedge clk);
        cfg_lim = 2'd0;

        // R2: only the gap-clock level of the width pin counts
        run_bw_flip(1'b1, lat);
        chk("R2 pin high then low gives 8-bit", lat, 12);
        run_bw_flip(1'b0, lat);
        chk("R2 pin low then high gives 16-bit", lat, 6);

        summary();
        $finish;
    end

endmodule